// File: doc/BRIEF.md
# NOR Flash Page-Program Write Buffer

This block stages data for a serial NOR flash and drives the program sequence on a mode-0 SPI link. Software picks one of two modes with a configuration bit. In page mode, a 256-byte buffer is filled through a 32-bit word port. In byte mode, one staged byte goes out per trigger. Software also sets a 24-bit target address through three byte-wide registers. It then writes the trigger bit of the command register, and that bit reads back as set until the flash sequence has been sent.

Every operation has two chip-select frames. The first frame carries the write-enable opcode alone. The second carries the page-program opcode, the three address bytes with the most significant byte first, and then the data: the whole page buffer in page mode, or the staged byte in byte mode. In byte mode the address register steps forward by one after each completed byte, so repeated triggers fill consecutive locations. While an operation runs, every register write is dropped.

The sequencer moves through five named states. IDLE goes to WREN when a trigger is accepted. WREN goes to GAP after its eighth falling clock edge. GAP goes to PROG after one half clock period with chip select high. PROG goes to FINISH after the falling edge of the last bit of the last byte. FINISH returns to IDLE after one cycle, and in that cycle it signals completion to the register file.

Top module: `nor_page_writer`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sck` is 0, `trig_busy` is 0 and `cur_addr` is 0.
- R2: A write with `reg_sel` 0 loads `cur_addr[7:0]`, with `reg_sel` 1 loads `cur_addr[15:8]`, and with `reg_sel` 2 loads `cur_addr[23:16]`, each from `reg_wdata[7:0]`.
- R3: Each operation begins with a chip-select frame of exactly one byte, 0x06. Chip select goes low in the same cycle that `trig_busy` rises.
- R4: The second frame carries 0x02, then address bits 23:16, 15:8 and 7:0, then the data bytes.
- R5: With mode bit `reg_wdata[0]`=1 written at `reg_sel` 3 (page mode), 64 writes at `reg_sel` 5 fill the page. A trigger sends 256 data bytes in address order, and within each word, bits 7:0 go first and bits 31:24 go last.
- R6: Writing `reg_wdata[4]`=1 at `reg_sel` 6 sets `trig_busy`, which stays 1 for the whole operation and returns to 0 when it ends. `spi_cs_n` is 1 whenever `trig_busy` is 0.
- R7: In byte mode (mode bit 0), the program frame carries exactly one data byte, the value last written at `reg_sel` 4, and `cur_addr` is one higher (modulo 2^24) after the operation. In page mode `cur_addr` is unchanged.
- R8: While `trig_busy` is 1, writes to any register are dropped, including data, address and further triggers.
- R9: The page write pointer returns to word 0 on every trigger and on every change of the mode bit from 0 to 1. A page-mode trigger always sends all 256 bytes, and bytes that were not rewritten keep their earlier values.
- R10: SPI mode 0 is used: `spi_sck` is 0 whenever chip select is high, bits go out MSB first, and `spi_mosi` does not change on a rising `spi_sck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0/1/2 address bytes, 3 mode, 4 byte data, 5 word port, 6 command |
| reg_wdata | input | 32 | Register write data |
| trig_busy | output | 1 | Read-back of the trigger bit; 1 while an operation runs |
| cur_addr | output | 24 | Current target address register |
| spi_sck | output | 1 | SPI serial clock |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data to the flash |

## Verification
The bench builds the block with its default 256-byte page, so the full 64-word fill and the 260-byte program frame are checked byte for byte. It also uses the fastest serial clock setting, a half period of one system clock, which keeps a full page operation near four thousand cycles. With that setting, back-to-back byte-mode triggers, an address carry across 0xFFFFFF, register writes that arrive in the middle of a frame, and partial page refills after a pointer reset can all be covered in one short run.

// File: rtl/npw_pkg.sv
package npw_pkg;

    localparam int ADDR_BYTES = 3;
    localparam int ADDR_W     = 8 * ADDR_BYTES;
    localparam int TRIG_BIT   = 4;

    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_PROG = 8'h02;

    typedef enum logic [2:0] {
        SEL_ADDR_LO  = 3'd0,
        SEL_ADDR_MID = 3'd1,
        SEL_ADDR_HI  = 3'd2,
        SEL_MODE     = 3'd3,
        SEL_BYTE     = 3'd4,
        SEL_WORD     = 3'd5,
        SEL_CMD      = 3'd6
    } npw_sel_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WREN,
        ST_GAP,
        ST_PROG,
        ST_FINISH
    } npw_state_e;

endpackage

// File: rtl/npw_regs.sv
module npw_regs
    import npw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [2:0]        sel,
    input  logic [7:0]        wdata,
    input  logic              op_done,
    output logic              start,
    output logic              busy,
    output logic [ADDR_W-1:0] addr,
    output logic              buf_mode,
    output logic [7:0]        single_byte,
    output logic              word_we,
    output logic              ptr_clr
);

    logic     wr_ok;
    npw_sel_e sel_e;

    assign sel_e   = npw_sel_e'(sel);
    assign wr_ok   = we && !busy;
    assign start   = wr_ok && (sel_e == SEL_CMD) && wdata[TRIG_BIT];
    assign word_we = wr_ok && (sel_e == SEL_WORD);
    assign ptr_clr = start || (wr_ok && (sel_e == SEL_MODE) && wdata[0] && !buf_mode);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy        <= 1'b0;
            addr        <= '0;
            buf_mode    <= 1'b0;
            single_byte <= '0;
        end else begin
            if (op_done) begin
                busy <= 1'b0;
                if (!buf_mode) begin
                    addr <= addr + ADDR_W'(1);
                end
            end else if (start) begin
                busy <= 1'b1;
            end
            if (wr_ok) begin
                unique case (sel_e)
                    SEL_ADDR_LO:  addr[7:0]   <= wdata;
                    SEL_ADDR_MID: addr[15:8]  <= wdata;
                    SEL_ADDR_HI:  addr[23:16] <= wdata;
                    SEL_MODE:     buf_mode    <= wdata[0];
                    SEL_BYTE:     single_byte <= wdata;
                    default:      ;
                endcase
            end
        end
    end

endmodule

// File: rtl/npw_page_buf.sv
module npw_page_buf #(
    parameter int PAGE_BYTES = 256,
    parameter int WORD_W     = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [WORD_W-1:0]             wr_word,
    input  logic                          ptr_clr,
    input  logic [$clog2(PAGE_BYTES)-1:0] rd_idx,
    output logic [7:0]                    rd_byte
);

    localparam int LANES  = WORD_W / 8;
    localparam int WORDS  = PAGE_BYTES / LANES;
    localparam int PTR_W  = $clog2(WORDS + 1);
    localparam int WIDX_W = $clog2(WORDS);
    localparam int LANE_W = $clog2(LANES);
    localparam int IDX_W  = $clog2(PAGE_BYTES);

    logic [WORD_W-1:0] mem [WORDS];
    logic [PTR_W-1:0]  wptr;
    logic              full;
    logic [WORD_W-1:0] rd_word;
    logic [7:0]        lane [LANES];

    assign full = (wptr == PTR_W'(WORDS));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
        end else if (ptr_clr) begin
            wptr <= '0;
        end else if (wr_en && !full) begin
            wptr <= wptr + PTR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !full && !ptr_clr) begin
            mem[wptr[WIDX_W-1:0]] <= wr_word;
        end
    end

    assign rd_word = mem[rd_idx[IDX_W-1:LANE_W]];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane[l] = rd_word[8*l +: 8];
    end

    assign rd_byte = lane[rd_idx[LANE_W-1:0]];

endmodule

// File: rtl/npw_sequencer.sv
module npw_sequencer
    import npw_pkg::*;
#(
    parameter int PAGE_BYTES = 256,
    parameter int SCK_HALF   = 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic                          buf_mode,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [7:0]                    single_byte,
    input  logic [7:0]                    buf_byte,
    output logic [$clog2(PAGE_BYTES)-1:0] rd_idx,
    output logic                          op_done,
    output logic                          sck,
    output logic                          cs_n,
    output logic                          mosi
);

    localparam int HDR   = 1 + ADDR_BYTES;
    localparam int CNT_W = $clog2(PAGE_BYTES + HDR + 1);
    localparam int IDX_W = $clog2(PAGE_BYTES);
    localparam int DIV_W = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;

    npw_state_e        state, state_nx;
    logic [DIV_W-1:0]  div_cnt;
    logic [2:0]        bit_idx;
    logic [CNT_W-1:0]  byte_idx;
    logic [CNT_W-1:0]  nb;
    logic [CNT_W-1:0]  rd_tmp;
    logic [7:0]        shreg;
    logic [7:0]        load_byte;
    logic [ADDR_W-1:0] addr_l;
    logic [ADDR_W-1:0] addr_sh;
    logic [7:0]        sbyte_l;
    logic              mode_l;
    logic              sck_q;
    logic              tick;
    logic              byte_end;
    logic              last_byte;
    logic              shifting;
    int                total;

    assign tick      = (div_cnt == DIV_W'(SCK_HALF - 1));
    assign byte_end  = tick && sck_q && (bit_idx == 3'd7);
    assign total     = mode_l ? (PAGE_BYTES + HDR) : (HDR + 1);
    assign last_byte = (int'(byte_idx) == total - 1);
    assign shifting  = (state == ST_WREN) || (state == ST_PROG);

    always_comb begin
        nb      = byte_idx + CNT_W'(1);
        rd_tmp  = nb - CNT_W'(HDR);
        rd_idx  = rd_tmp[IDX_W-1:0];
        addr_sh = addr_l >> (8 * (ADDR_BYTES - int'(nb)));
        if (int'(nb) <= ADDR_BYTES) begin
            load_byte = addr_sh[7:0];
        end else if (mode_l) begin
            load_byte = buf_byte;
        end else begin
            load_byte = sbyte_l;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start)                  state_nx = ST_WREN;
            ST_WREN:   if (byte_end)               state_nx = ST_GAP;
            ST_GAP:    if (tick)                   state_nx = ST_PROG;
            ST_PROG:   if (byte_end && last_byte)  state_nx = ST_FINISH;
            ST_FINISH:                             state_nx = ST_IDLE;
            default:                               state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt  <= '0;
            bit_idx  <= '0;
            byte_idx <= '0;
            shreg    <= '0;
            sck_q    <= 1'b0;
            addr_l   <= '0;
            sbyte_l  <= '0;
            mode_l   <= 1'b0;
        end else begin
            if (state == ST_IDLE || state == ST_FINISH || tick) begin
                div_cnt <= '0;
            end else begin
                div_cnt <= div_cnt + DIV_W'(1);
            end
            unique case (state)
                ST_IDLE: begin
                    sck_q <= 1'b0;
                    if (start) begin
                        shreg    <= OP_WREN;
                        bit_idx  <= '0;
                        byte_idx <= '0;
                        addr_l   <= addr;
                        sbyte_l  <= single_byte;
                        mode_l   <= buf_mode;
                    end
                end
                ST_WREN, ST_PROG: begin
                    if (tick) begin
                        if (!sck_q) begin
                            sck_q <= 1'b1;
                        end else begin
                            sck_q <= 1'b0;
                            if (bit_idx == 3'd7) begin
                                bit_idx  <= '0;
                                byte_idx <= nb;
                                shreg    <= load_byte;
                            end else begin
                                bit_idx <= bit_idx + 3'd1;
                                shreg   <= {shreg[6:0], 1'b0};
                            end
                        end
                    end
                end
                ST_GAP: begin
                    sck_q <= 1'b0;
                    if (tick) begin
                        shreg    <= OP_PROG;
                        bit_idx  <= '0;
                        byte_idx <= '0;
                    end
                end
                ST_FINISH: sck_q <= 1'b0;
                default:   sck_q <= 1'b0;
            endcase
        end
    end

    always_comb begin
        cs_n    = !shifting;
        sck     = sck_q;
        mosi    = shifting ? shreg[7] : 1'b0;
        op_done = (state == ST_FINISH);
    end

endmodule

// File: rtl/nor_page_writer.sv
module nor_page_writer
    import npw_pkg::*;
#(
    parameter int PAGE_BYTES = 256,
    parameter int WORD_W     = 32,
    parameter int SCK_HALF   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic              trig_busy,
    output logic [23:0]       cur_addr,
    output logic              spi_sck,
    output logic              spi_cs_n,
    output logic              spi_mosi
);

    localparam int IDX_W = $clog2(PAGE_BYTES);

    logic             start;
    logic             op_done;
    logic             cfg_buf_mode;
    logic [7:0]       single_byte;
    logic             word_we;
    logic             ptr_clr;
    logic [IDX_W-1:0] rd_idx;
    logic [7:0]       buf_byte;

    npw_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (reg_we),
        .sel         (reg_sel),
        .wdata       (reg_wdata[7:0]),
        .op_done     (op_done),
        .start       (start),
        .busy        (trig_busy),
        .addr        (cur_addr),
        .buf_mode    (cfg_buf_mode),
        .single_byte (single_byte),
        .word_we     (word_we),
        .ptr_clr     (ptr_clr)
    );

    npw_page_buf #(
        .PAGE_BYTES (PAGE_BYTES),
        .WORD_W     (WORD_W)
    ) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (word_we),
        .wr_word (reg_wdata[WORD_W-1:0]),
        .ptr_clr (ptr_clr),
        .rd_idx  (rd_idx),
        .rd_byte (buf_byte)
    );

    npw_sequencer #(
        .PAGE_BYTES (PAGE_BYTES),
        .SCK_HALF   (SCK_HALF)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .buf_mode    (cfg_buf_mode),
        .addr        (cur_addr),
        .single_byte (single_byte),
        .buf_byte    (buf_byte),
        .rd_idx      (rd_idx),
        .op_done     (op_done),
        .sck         (spi_sck),
        .cs_n        (spi_cs_n),
        .mosi        (spi_mosi)
    );

endmodule

// File: rtl/npw_checker.sv
module npw_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        cs_n,
    input logic        sck,
    input logic        mosi,
    input logic [23:0] addr,
    input logic        buf_mode
);

    AST_IDLE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cs_n); // R6

    AST_SCK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck); // R10

    AST_TRIGGER_OPENS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !cs_n); // R3

    AST_ADDR_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(addr)); // R8

    AST_SINGLE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !buf_mode) |-> (addr == $past(addr) + 24'd1)); // R7

    AST_PAGE_ADDR_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && buf_mode) |-> $stable(addr)); // R7

    AST_MOSI_STABLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $rose(sck)) |-> $stable(mosi)); // R10

endmodule

bind nor_page_writer npw_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (trig_busy),
    .cs_n     (spi_cs_n),
    .sck      (spi_sck),
    .mosi     (spi_mosi),
    .addr     (cur_addr),
    .buf_mode (cfg_buf_mode)
);

// File: tb/nor_page_writer_test.sv
module nor_page_writer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic        trig_busy;
    logic [23:0] cur_addr;
    logic        spi_sck;
    logic        spi_cs_n;
    logic        spi_mosi;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [7:0] fb [0:4095];
    int         flen [0:7];
    int         fcnt = 0;
    int         bcnt = 0;
    logic [7:0] sh = '0;
    logic [7:0] page [0:255];
    logic [7:0] exp_fr [0:263];

    always #5 clk = ~clk;

    nor_page_writer uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .trig_busy (trig_busy),
        .cur_addr  (cur_addr),
        .spi_sck   (spi_sck),
        .spi_cs_n  (spi_cs_n),
        .spi_mosi  (spi_mosi)
    );

    // SPI monitor: capture on rising clock, close a frame on chip-select release
    always @(posedge spi_sck or posedge spi_cs_n) begin
        if (spi_cs_n) begin
            if (fcnt < 8) begin
                flen[fcnt] = bcnt / 8;
                fcnt++;
            end
            bcnt = 0;
        end else begin
            sh = {sh[6:0], spi_mosi};
            bcnt++;
            if (bcnt % 8 == 0 && fcnt < 8 && bcnt / 8 <= 512)
                fb[fcnt * 512 + bcnt / 8 - 1] = sh;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000 && trig_busy; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic set_addr(input logic [23:0] a);
        reg_wr(3'd0, {24'd0, a[7:0]});
        reg_wr(3'd1, {24'd0, a[15:8]});
        reg_wr(3'd2, {24'd0, a[23:16]});
    endtask

    // Compare two captured frames: write-enable, then program with n data bytes in exp_fr
    task automatic chk_op(input string req, input int n);
        chk(fcnt == 2, "R3", "frame count", fcnt, 2);
        chk(flen[0] == 1 && fb[0] == 8'h06, "R3", "write-enable frame",
            {flen[0], fb[0]}, {32'd1, 8'h06});
        chk(flen[1] == n + 4, req, "program frame length", flen[1], n + 4);
        for (int i = 0; i < n + 4; i++)
            chk(fb[512 + i] === exp_fr[i], (i < 4) ? "R4" : req, $sformatf("byte %0d", i),
                fb[512 + i], exp_fr[i]);
    endtask

    task automatic single_op(input logic [23:0] a, input logic [7:0] d, input string req);
        fcnt = 0;
        reg_wr(3'd4, {24'd0, d});
        reg_wr(3'd6, 32'h10);
        chk(trig_busy == 1'b1, "R6", "busy after trigger", trig_busy, 1);
        wait_idle();
        chk(trig_busy == 1'b0, "R6", "trigger bit cleared", trig_busy, 0);
        exp_fr[0] = 8'h02; exp_fr[1] = a[23:16]; exp_fr[2] = a[15:8]; exp_fr[3] = a[7:0];
        exp_fr[4] = d;
        chk_op(req, 1);
        chk(cur_addr == a + 24'd1, "R7", "address advanced", cur_addr, a + 24'd1);
    endtask

    task automatic t_reset();
        chk(spi_cs_n == 1'b1, "R1", "cs_n at reset", spi_cs_n, 1);
        chk(spi_sck == 1'b0, "R1", "sck at reset", spi_sck, 0);
        chk(trig_busy == 1'b0, "R1", "busy at reset", trig_busy, 0);
        chk(cur_addr == 24'd0, "R1", "address at reset", cur_addr, 0);
    endtask

    task automatic t_addr();
        set_addr(24'h123456);
        chk(cur_addr == 24'h123456, "R2", "address byte lanes", cur_addr, 24'h123456);
        reg_wr(3'd1, 32'hAB);
        chk(cur_addr == 24'h12AB56, "R2", "middle byte only", cur_addr, 24'h12AB56);
    endtask

    task automatic t_single();
        reg_wr(3'd3, 32'h0);
        set_addr(24'h00A0FF);
        single_op(24'h00A0FF, 8'hA5, "R7");
        single_op(24'h00A100, 8'h3C, "R7");
        set_addr(24'hFFFFFF);
        single_op(24'hFFFFFF, 8'h81, "R7");
        chk(cur_addr == 24'h000000, "R7", "address wraps", cur_addr, 0);
    endtask

    task automatic t_busy_drop();
        set_addr(24'h004000);
        fcnt = 0;
        reg_wr(3'd4, 32'h5A);
        reg_wr(3'd6, 32'h10);
        repeat (10) @(negedge clk);
        reg_wr(3'd4, 32'hEE);
        reg_wr(3'd0, 32'h77);
        reg_wr(3'd5, 32'hDEADBEEF);
        reg_wr(3'd3, 32'h1);
        reg_wr(3'd6, 32'h10);
        wait_idle();
        exp_fr[0] = 8'h02; exp_fr[1] = 8'h00; exp_fr[2] = 8'h40; exp_fr[3] = 8'h00;
        exp_fr[4] = 8'h5A;
        chk_op("R8", 1);
        chk(cur_addr == 24'h004001, "R8", "address write dropped", cur_addr, 24'h004001);
        // staged byte and mode must still be the values from before the busy window
        single_op(24'h004001, 8'h5A, "R8");
    endtask

    task automatic fill_words(input int first, input int n, input int seed);
        for (int w = first; w < first + n; w++) begin
            logic [31:0] word;
            for (int b = 0; b < 4; b++) begin
                page[4 * w + b] = 8'((4 * w + b) * 7 + seed);
                word[8 * b +: 8] = page[4 * w + b];
            end
            reg_wr(3'd5, word);
        end
    endtask

    task automatic page_op(input logic [23:0] a, input string req);
        fcnt = 0;
        reg_wr(3'd6, 32'h10);
        chk(trig_busy == 1'b1, "R6", "busy after page trigger", trig_busy, 1);
        wait_idle();
        exp_fr[0] = 8'h02; exp_fr[1] = a[23:16]; exp_fr[2] = a[15:8]; exp_fr[3] = a[7:0];
        for (int i = 0; i < 256; i++) exp_fr[4 + i] = page[i];
        chk_op(req, 256);
        chk(cur_addr == a, "R7", "page address kept", cur_addr, a);
    endtask

    task automatic t_buffer();
        reg_wr(3'd3, 32'h0);
        reg_wr(3'd3, 32'h1);
        set_addr(24'h012300);
        fill_words(0, 64, 3);
        page_op(24'h012300, "R5");
    endtask

    task automatic t_ptr();
        // pointer reset by the previous trigger: two words land at the start
        fill_words(0, 2, 101);
        page_op(24'h012300, "R9");
        // pointer reset by re-entering page mode
        fill_words(0, 1, 55);
        reg_wr(3'd3, 32'h0);
        reg_wr(3'd3, 32'h1);
        fill_words(0, 1, 200);
        page_op(24'h012300, "R9");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_addr();
        t_single();
        t_busy_drop();
        t_buffer();
        t_ptr();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule